// File: doc/BRIEF.md
# Per-Task Software Interrupt Router

This block sits between eight accelerator tasks and the host CPU's interrupt inputs. For each task it picks which event reaches the host. The first choice is the automatic end-of-task pulse. The second is a software interrupt that the task raises itself, by writing a force register from the accelerator side. A per-task mask register selects the source for each task. A task whose mask bit is set never shows its end-of-task pulse to the host. It can still signal the host through a forced interrupt whenever its code chooses.

The block has two register write ports. The accelerator side can write both registers. The host side has a write port, but every write made through it is discarded. Both sides can read the mask. A forced interrupt is a one-cycle pulse, and it is merged by OR with any routed end-of-task pulse on the same output line. Every output pulse appears one clock after its cause.

Top module: `sw_int_router`

## Requirements
- R1: After reset the mask register is 0, every `hostIrq` bit is 0, and both read ports return 0.
- R2: When a task's mask bit is 0, a one-cycle pulse on its `eotPulse` bit gives a one-cycle pulse on the matching `hostIrq` bit in the next cycle.
- R3: When a task's mask bit is 1, that task's `eotPulse` never reaches `hostIrq`.
- R4: An accelerator write to the force register (`accWrSel`=1) pulses `hostIrq` for one cycle in the next cycle for every data bit 7:0 that is 1, whatever the mask holds.
- R5: Force bits that are written as 0 raise nothing. Reading the force register (`accRdSel`=1) always returns 0. A force write leaves the mask unchanged.
- R6: Host-side writes to the mask (`hostWrSel`=0) or to the force register (`hostWrSel`=1) change no state and raise no interrupt.
- R7: An accelerator write to the mask (`accWrSel`=0) loads data bits 7:0, with bit i standing for task i. `hostRdData` returns the mask, and so does `accRdData` with `accRdSel`=0.
- R8: A forced pulse and a routed end-of-task pulse in the same cycle both appear on `hostIrq` in the next cycle, combined by OR.
- R9: Write data bits 15:8 are discarded, and bits 15:8 of both read ports are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| eotPulse | input | 8 | End-of-task pulses, one per task |
| accWrEn | input | 1 | Accelerator write strobe |
| accWrSel | input | 1 | Accelerator write target: 0 mask, 1 force |
| accWrData | input | 16 | Accelerator write data |
| accRdSel | input | 1 | Accelerator read target: 0 mask, 1 force |
| accRdData | output | 16 | Accelerator read data |
| hostWrEn | input | 1 | Host write strobe (discarded) |
| hostWrSel | input | 1 | Host write target (discarded) |
| hostWrData | input | 16 | Host write data (discarded) |
| hostRdData | output | 16 | Host read data, the mask |
| hostIrq | output | 8 | Interrupt pulses to the host |

## Verification
The bench sets the mask so that masked and unmasked tasks see the same end-of-task burst. If the mask polarity were inverted or ignored, the wrong subset of `hostIrq` bits would rise. It forces tasks whose mask bit is set, and also drives a force and an end-of-task event in the same cycle. A design that gated forces by the mask, or chose one source over the other, would drop bits. It tries both host write targets with all bits set and checks the mask read and the interrupt lines afterwards. It also checks that a pulse lasts exactly one cycle and that bits 15:8 are discarded, which finds a level-held interrupt or upper bits that get stored.

// File: rtl/sw_int_router_pkg.sv
package sw_int_router_pkg;
  parameter int TASK_CNT = 8;
  parameter int REG_W    = 16;

  typedef struct packed {
    logic                maskLoad;
    logic [TASK_CNT-1:0] maskBits;
    logic [TASK_CNT-1:0] forceBits;
  } ctlStrobes_t;
endpackage

// File: rtl/sw_int_ctl.sv
module sw_int_ctl
  import sw_int_router_pkg::*;
#(
  parameter int TASKS = TASK_CNT,
  parameter int W     = REG_W
) (
  input  logic         accWrEn,
  input  logic         accWrSel,
  input  logic [W-1:0] accWrData,
  input  logic         hostWrEn,
  input  logic         hostWrSel,
  input  logic [W-1:0] hostWrData,
  output ctlStrobes_t  strobes
);
  localparam int SPARE_W = W - TASKS;

  logic unusedBits;
  assign unusedBits = ^{hostWrEn, hostWrSel, hostWrData, accWrData[W-1:W-SPARE_W]};

  always_comb begin
    strobes.maskLoad  = accWrEn && !accWrSel;
    strobes.maskBits  = accWrData[TASKS-1:0];
    strobes.forceBits = (accWrEn && accWrSel) ? accWrData[TASKS-1:0] : '0;
  end
endmodule

// File: rtl/sw_int_datapath.sv
module sw_int_datapath
  import sw_int_router_pkg::*;
#(
  parameter int TASKS = TASK_CNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [TASKS-1:0] eotPulse,
  output logic [TASKS-1:0] maskQ,
  output logic [TASKS-1:0] irqQ
);
  logic [TASKS-1:0] irqNext;

  for (genvar t = 0; t < TASKS; t++) begin : g_task
    assign irqNext[t] = (eotPulse[t] & ~maskQ[t]) | strobes.forceBits[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      irqQ  <= '0;
    end else begin
      irqQ <= irqNext;
      if (strobes.maskLoad) maskQ <= strobes.maskBits;
    end
  end
endmodule

// File: rtl/sw_int_router.sv
module sw_int_router
  import sw_int_router_pkg::*;
#(
  parameter int TASKS = TASK_CNT,
  parameter int W     = REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TASKS-1:0] eotPulse,
  input  logic             accWrEn,
  input  logic             accWrSel,
  input  logic [W-1:0]     accWrData,
  input  logic             accRdSel,
  output logic [W-1:0]     accRdData,
  input  logic             hostWrEn,
  input  logic             hostWrSel,
  input  logic [W-1:0]     hostWrData,
  output logic [W-1:0]     hostRdData,
  output logic [TASKS-1:0] hostIrq
);
  localparam int PAD_W = W - TASKS;

  ctlStrobes_t      strobes;
  logic [TASKS-1:0] maskQ;

  sw_int_ctl #(.TASKS(TASKS), .W(W)) u_ctl (
    .accWrEn   (accWrEn),
    .accWrSel  (accWrSel),
    .accWrData (accWrData),
    .hostWrEn  (hostWrEn),
    .hostWrSel (hostWrSel),
    .hostWrData(hostWrData),
    .strobes   (strobes)
  );

  sw_int_datapath #(.TASKS(TASKS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .eotPulse(eotPulse),
    .maskQ   (maskQ),
    .irqQ    (hostIrq)
  );

  assign hostRdData = {{PAD_W{1'b0}}, maskQ};
  assign accRdData  = accRdSel ? '0 : {{PAD_W{1'b0}}, maskQ};
endmodule

// File: rtl/sw_int_router_checker.sv
module sw_int_router_checker #(
  parameter int TASKS = 8,
  parameter int W     = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [TASKS-1:0] eotPulse,
  input logic             accWrEn,
  input logic             accWrSel,
  input logic [W-1:0]     accWrData,
  input logic             accRdSel,
  input logic [W-1:0]     accRdData,
  input logic             hostWrEn,
  input logic [W-1:0]     hostRdData,
  input logic [TASKS-1:0] hostIrq
);
  logic [TASKS-1:0] forceIn;
  logic [TASKS-1:0] masked;
  assign forceIn = (accWrEn && accWrSel) ? accWrData[TASKS-1:0] : '0;
  assign masked  = hostRdData[TASKS-1:0];

  a_r2_route: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hostIrq & $past(eotPulse & ~masked)) == $past(eotPulse & ~masked)));

  a_r3_suppress: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((hostIrq & $past(eotPulse & masked & ~forceIn)) == '0));

  a_r4_force: assert property (@(posedge clk) disable iff (!rstN)
    (accWrEn && accWrSel) |=> ((hostIrq & $past(forceIn)) == $past(forceIn)));

  a_r6_host_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !(accWrEn && !accWrSel)) |=> $stable(hostRdData));

  a_r5_force_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    accRdSel |-> (accRdData == '0));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdData[W-1:TASKS] == '0) && (accRdData[W-1:TASKS] == '0));
endmodule

bind sw_int_router sw_int_router_checker #(.TASKS(TASKS), .W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .eotPulse  (eotPulse),
  .accWrEn   (accWrEn),
  .accWrSel  (accWrSel),
  .accWrData (accWrData),
  .accRdSel  (accRdSel),
  .accRdData (accRdData),
  .hostWrEn  (hostWrEn),
  .hostRdData(hostRdData),
  .hostIrq   (hostIrq)
);

// File: tb/test_sw_int_router.sv
module test_sw_int_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  eotPulse = '0;
  logic        accWrEn = 1'b0, accWrSel = 1'b0, accRdSel = 1'b0;
  logic [15:0] accWrData = '0;
  logic [15:0] accRdData;
  logic        hostWrEn = 1'b0, hostWrSel = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic [7:0]  hostIrq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_int_router i_sw_int_router (
    .clk(clk), .rstN(rstN), .eotPulse(eotPulse),
    .accWrEn(accWrEn), .accWrSel(accWrSel), .accWrData(accWrData),
    .accRdSel(accRdSel), .accRdData(accRdData),
    .hostWrEn(hostWrEn), .hostWrSel(hostWrSel), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostIrq(hostIrq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle starting at a negedge; returns at the next negedge
  task automatic cycle(input logic [7:0] eot, input logic aEn, input logic aSel,
                       input logic [15:0] aData, input logic hEn, input logic hSel,
                       input logic [15:0] hData);
    eotPulse = eot; accWrEn = aEn; accWrSel = aSel; accWrData = aData;
    hostWrEn = hEn; hostWrSel = hSel; hostWrData = hData;
    @(negedge clk);
    eotPulse = '0; accWrEn = 1'b0; accWrSel = 1'b0; accWrData = '0;
    hostWrEn = 1'b0; hostWrSel = 1'b0; hostWrData = '0;
  endtask

  task automatic testReset();
    check("R1 irq", {8'h0, hostIrq}, 16'h0);
    check("R1 hostRd", hostRdData, 16'h0);
    accRdSel = 1'b0; #1;
    check("R1 accRd", accRdData, 16'h0);
  endtask

  task automatic testRouteUnmasked();
    cycle(8'h05, 0, 0, 0, 0, 0, 0);
    check("R2 pulse", {8'h0, hostIrq}, 16'h0005);
    @(negedge clk);
    check("R2 one cycle", {8'h0, hostIrq}, 16'h0000);
  endtask

  task automatic testMaskWrite();
    cycle(8'h00, 1, 0, 16'hFF3C, 0, 0, 0);
    check("R7 hostRd", hostRdData, 16'h003C);
    accRdSel = 1'b0; #1;
    check("R9 accRd upper", accRdData, 16'h003C);
  endtask

  task automatic testSuppress();
    cycle(8'hFF, 0, 0, 0, 0, 0, 0);
    check("R3 masked eot", {8'h0, hostIrq}, 16'h00C3);
  endtask

  task automatic testForce();
    cycle(8'h00, 1, 1, 16'hFF3C, 0, 0, 0);
    check("R4 force masked tasks", {8'h0, hostIrq}, 16'h003C);
    @(negedge clk);
    check("R4 one cycle", {8'h0, hostIrq}, 16'h0000);
    accRdSel = 1'b1; #1;
    check("R5 force reads 0", accRdData, 16'h0000);
    accRdSel = 1'b0;
    cycle(8'h00, 1, 1, 16'h0000, 0, 0, 0);
    check("R5 zero force", {8'h0, hostIrq}, 16'h0000);
    check("R5 mask kept", hostRdData, 16'h003C);
  endtask

  task automatic testMerge();
    cycle(8'h05, 1, 1, 16'h0080, 0, 0, 0);
    check("R8 merge", {8'h0, hostIrq}, 16'h0081);
  endtask

  task automatic testHostIgnored();
    cycle(8'h00, 0, 0, 0, 1, 0, 16'hFFFF);
    check("R6 host mask write", hostRdData, 16'h003C);
    cycle(8'h00, 0, 0, 0, 1, 1, 16'hFFFF);
    check("R6 host force write", {8'h0, hostIrq}, 16'h0000);
    check("R6 mask after force", hostRdData, 16'h003C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRouteUnmasked();
    testMaskWrite();
    testSuppress();
    testForce();
    testMerge();
    testHostIgnored();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule